// File: doc/BRIEF.md
# Page-Mode DRAM Strobe Controller

This block sits between a synchronous host and an asynchronous DRAM array built from several modules. The host issues one word read or write at a time over a valid/ready handshake. The controller splits the flat word address into three fields: a module index, a row and a column. It then produces the active-low row strobe, column strobe, write enable and output enable. The row and column share one multiplexed address bus. The data bus is shared and tri-stated.

After an access, the row stays open: the row strobe of that module remains asserted. A later request to the same module and row costs only a column cycle. A request that lands elsewhere first closes the open row, waits a precharge interval, and then opens the new row. Each module has its own row strobe line. Column strobe, enables, address and data are common to all modules. The data pad direction is driven by a separate output-enable signal, so the pad ring can build the bidirectional pin.

Top module: `pgdram_ctrl`

## Requirements
- R1: After reset, every row strobe, the column strobe, write enable and output enable are high. Data drive is off, `req_ready` is 1 and `rsp_valid` is 0.
- R2: The flat address is {module, row, column}, with the column in the low COL_W bits and the row in the next ROW_W bits. `dram_a` carries the row in the cycle the row strobe falls, and the column in the cycle the column strobe falls.
- R3: At most one row strobe is low at any time. The line that falls is the one whose index equals the module field of the request.
- R4: A request to the open module and row (a page hit) causes no row strobe transition. It keeps `req_ready` low for exactly T_CAS+2 cycles.
- R5: A request that misses an open row raises its row strobe. All row strobes then stay high for T_PRE+1 cycles before the new row strobe falls, and `req_ready` stays low for T_PRE+T_RCD+T_CAS+3 cycles. With no row open (as after reset), a request is busy for T_RCD+T_CAS+3 cycles.
- R6: After a row opens, the column strobe falls exactly T_RCD+1 cycles after the row strobe fell. Every column strobe pulse lasts exactly T_CAS cycles, and the column strobe is low only while some row strobe is low.
- R7: In a write, write enable is low and data drive is on from the cycle before the column strobe falls until the cycle after it rises. Output enable stays high, and `dram_dq_out` carries the request's write data throughout.
- R8: In a read, output enable is low exactly while the column strobe is low, write enable stays high and data drive is off. The data bus is sampled on the last column-low clock. It is returned with a single-cycle `rsp_valid` in the cycle after the column strobe rises.
- R9: Write enable and output enable are never low together.
- R10: A request is accepted when `req_valid` and `req_ready` are both 1. `req_ready` is 0 in the cycle that follows acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | MOD_W+ROW_W+COL_W | Flat word address {module, row, column} |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W | Read data |
| dram_ras_n | output | MOD_CNT | Per-module row strobes, active low |
| dram_cas_n | output | 1 | Shared column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_a | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_out | output | DATA_W | Data toward the DRAM |
| dram_dq_oe | output | 1 | Data pad drive enable |
| dram_dq_in | input | DATA_W | Data from the DRAM |

## Verification
The assertions take three things for granted. The timing parameters are at least 1. The host presents a request's address, direction and data in the acceptance cycle. The DRAM returns valid read data by the last column-low clock while output enable and the column strobe are both low. The bench keeps to these assumptions. Its memory model drives the data bus only when output enable and the column strobe are both low, and indexes it with the row it latched at the row strobe fall and the column latched at the column strobe fall. It issues exactly one request at a time, holding `req_valid` for a single accepted cycle. The sweep writes every address of a four-module, four-row, four-column configuration and then reads them back in a permuted order. This mixes page hits, row misses and module switches.

// File: rtl/pgdram_pkg.sv
`timescale 1ns/1ps
package pgdram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ROWSET,
    ST_ACT,
    ST_COLSET,
    ST_CAS,
    ST_CREC
  } dstate_e;

  // non-idle cycles spent on one access
  function automatic int busy_cycles(input bit hit, input bit was_open,
                                     input int tp, input int tr, input int tc);
    if (hit) return tc + 2;
    return (was_open ? tp : 0) + tr + tc + 3;
  endfunction

endpackage

// File: rtl/pgdram_rowtrack.sv
`timescale 1ns/1ps
module pgdram_rowtrack #(
  parameter int MOD_W = 3,
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MOD_W-1:0] cmp_mod,
  input  logic [ROW_W-1:0] cmp_row,
  input  logic             set_en,
  input  logic [MOD_W-1:0] set_mod,
  input  logic [ROW_W-1:0] set_row,
  input  logic             clr_en,
  output logic             hit,
  output logic             open_valid,
  output logic [MOD_W-1:0] open_mod
);

  logic [ROW_W-1:0] open_row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_valid <= 1'b0;
      open_mod   <= '0;
      open_row   <= '0;
    end else if (clr_en) begin
      open_valid <= 1'b0;
    end else if (set_en) begin
      open_valid <= 1'b1;
      open_mod   <= set_mod;
      open_row   <= set_row;
    end
  end

  assign hit = open_valid && (cmp_mod == open_mod) && (cmp_row == open_row);

  // a new row is opened only after the previous one was closed
  assert_open_after_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !open_valid);

  assert_no_set_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en && clr_en));

endmodule

// File: rtl/pgdram_rasdec.sv
`timescale 1ns/1ps
module pgdram_rasdec #(
  parameter int MOD_CNT = 8,
  parameter int MOD_W   = 3
) (
  input  logic             open_valid,
  input  logic [MOD_W-1:0] open_mod,
  output logic [MOD_CNT-1:0] ras_n
);

  for (genvar g = 0; g < MOD_CNT; g++) begin : g_line
    assign ras_n[g] = !(open_valid && (open_mod == MOD_W'(g)));
  end

  always_comb begin
    assert_one_line_R3: assert ($onehot0(~ras_n));
  end

endmodule

// File: rtl/pgdram_fsm.sv
`timescale 1ns/1ps
module pgdram_fsm
  import pgdram_pkg::*;
#(
  parameter int T_PRE = 2,
  parameter int T_RCD = 2,
  parameter int T_CAS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic go_write,
  input  logic row_hit,
  input  logic row_open,
  output logic ready,
  output logic cas_n,
  output logic we_n,
  output logic oe_n,
  output logic drive,
  output logic col_phase,
  output logic cas_last,
  output logic open_set,
  output logic close_row
);

  localparam int TMAX   = (T_PRE > T_RCD) ? ((T_PRE > T_CAS) ? T_PRE : T_CAS)
                                          : ((T_RCD > T_CAS) ? T_RCD : T_CAS);
  localparam int CNT_W  = $clog2(TMAX + 1);
  localparam int BUSY_W = $clog2(T_PRE + T_RCD + T_CAS + 4) + 1;

  dstate_e          state;
  logic [CNT_W-1:0] cnt;
  logic             wr_q;
  logic             hit_q;
  logic             open_q;
  logic [BUSY_W-1:0] busy_cnt;
  logic             cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      wr_q   <= 1'b0;
      hit_q  <= 1'b0;
      open_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (go) begin
          wr_q   <= go_write;
          hit_q  <= row_hit;
          open_q <= row_open;
          if (row_hit) begin
            state <= ST_COLSET;
          end else if (row_open) begin
            state <= ST_PRE;
            cnt   <= CNT_W'(T_PRE - 1);
          end else begin
            state <= ST_ROWSET;
          end
        end
        ST_PRE: if (cnt_zero) state <= ST_ROWSET;
                else cnt <= cnt - 1'b1;
        ST_ROWSET: begin
          state <= ST_ACT;
          cnt   <= CNT_W'(T_RCD - 1);
        end
        ST_ACT: if (cnt_zero) state <= ST_COLSET;
                else cnt <= cnt - 1'b1;
        ST_COLSET: begin
          state <= ST_CAS;
          cnt   <= CNT_W'(T_CAS - 1);
        end
        ST_CAS: if (cnt_zero) state <= ST_CREC;
                else cnt <= cnt - 1'b1;
        ST_CREC: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || state == ST_IDLE) busy_cnt <= '0;
    else                            busy_cnt <= busy_cnt + 1'b1;
  end

  assign ready     = (state == ST_IDLE);
  assign col_phase = (state == ST_COLSET) || (state == ST_CAS) || (state == ST_CREC);
  assign cas_n     = !(state == ST_CAS);
  assign drive     = wr_q && col_phase;
  assign we_n      = !drive;
  assign oe_n      = !(!wr_q && state == ST_CAS);
  assign cas_last  = (state == ST_CAS) && cnt_zero;
  assign open_set  = (state == ST_ROWSET);
  assign close_row = ready && go && !row_hit && row_open;

  // access length matches hit / miss / cold case
  assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CREC) |-> (int'(busy_cnt) + 1 ==
                            busy_cycles(hit_q, open_q, T_PRE, T_RCD, T_CAS)));

  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !ready);

  assert_we_oe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));

  assert_cas_follows_colset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $past(col_phase));

endmodule

// File: rtl/pgdram_ctrl.sv
`timescale 1ns/1ps
module pgdram_ctrl #(
  parameter int MOD_CNT = 8,
  parameter int ROW_W   = 9,
  parameter int COL_W   = 9,
  parameter int DATA_W  = 8,
  parameter int T_PRE   = 2,
  parameter int T_RCD   = 2,
  parameter int T_CAS   = 2,
  localparam int MOD_W  = (MOD_CNT > 1) ? $clog2(MOD_CNT) : 1,
  localparam int ADDR_W = MOD_W + ROW_W + COL_W,
  localparam int A_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic [MOD_CNT-1:0] dram_ras_n,
  output logic               dram_cas_n,
  output logic               dram_we_n,
  output logic               dram_oe_n,
  output logic [A_W-1:0]     dram_a,
  output logic [DATA_W-1:0]  dram_dq_out,
  output logic               dram_dq_oe,
  input  logic [DATA_W-1:0]  dram_dq_in
);

  function automatic logic [COL_W-1:0] col_of(input logic [ADDR_W-1:0] a);
    return a[COL_W-1:0];
  endfunction

  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[COL_W +: ROW_W];
  endfunction

  function automatic logic [MOD_W-1:0] mod_of(input logic [ADDR_W-1:0] a);
    return a[COL_W + ROW_W +: MOD_W];
  endfunction

  logic             go;
  logic             row_hit;
  logic             row_open;
  logic [MOD_W-1:0] open_mod;
  logic             open_set;
  logic             close_row;
  logic             col_phase;
  logic             cas_last;
  logic             drive;
  logic [MOD_W-1:0] mod_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [DATA_W-1:0] wdata_q;

  assign go = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mod_q   <= '0;
      row_q   <= '0;
      col_q   <= '0;
      wdata_q <= '0;
    end else if (go) begin
      mod_q   <= mod_of(req_addr);
      row_q   <= row_of(req_addr);
      col_q   <= col_of(req_addr);
      wdata_q <= req_wdata;
    end
  end

  pgdram_rowtrack #(.MOD_W(MOD_W), .ROW_W(ROW_W)) u_rowtrack (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_mod    (mod_of(req_addr)),
    .cmp_row    (row_of(req_addr)),
    .set_en     (open_set),
    .set_mod    (mod_q),
    .set_row    (row_q),
    .clr_en     (close_row),
    .hit        (row_hit),
    .open_valid (row_open),
    .open_mod   (open_mod)
  );

  pgdram_fsm #(.T_PRE(T_PRE), .T_RCD(T_RCD), .T_CAS(T_CAS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .go_write  (req_write),
    .row_hit   (row_hit),
    .row_open  (row_open),
    .ready     (req_ready),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n),
    .oe_n      (dram_oe_n),
    .drive     (drive),
    .col_phase (col_phase),
    .cas_last  (cas_last),
    .open_set  (open_set),
    .close_row (close_row)
  );

  pgdram_rasdec #(.MOD_CNT(MOD_CNT), .MOD_W(MOD_W)) u_rasdec (
    .open_valid (row_open),
    .open_mod   (open_mod),
    .ras_n      (dram_ras_n)
  );

  assign dram_a      = col_phase ? A_W'(col_q) : A_W'(row_q);
  assign dram_dq_out = wdata_q;
  assign dram_dq_oe  = drive;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= cas_last && !dram_oe_n;
      if (cas_last && !dram_oe_n) rsp_rdata <= dram_dq_in;
    end
  end

  assert_cas_under_ras_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> (dram_ras_n != '1));

  assert_rsp_after_cas_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (dram_cas_n && !$past(dram_cas_n)));

  assert_rsp_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_wdata_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_dq_oe && $past(dram_dq_oe)) |-> $stable(dram_dq_out));

  assert_ras_steady_in_col_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (col_phase && $past(col_phase)) |-> $stable(dram_ras_n));

endmodule

// File: tb/pgdram_ctrl_tb.sv
`timescale 1ns/1ps
module pgdram_ctrl_tb;

  localparam int MODS = 4;
  localparam int RW   = 2;
  localparam int CW   = 2;
  localparam int DW   = 8;
  localparam int TP   = 2;
  localparam int TR   = 2;
  localparam int TC   = 2;
  localparam int NADDR = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [5:0]    req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [MODS-1:0] dram_ras_n;
  logic          dram_cas_n, dram_we_n, dram_oe_n;
  logic [1:0]    dram_a;
  logic [DW-1:0] dram_dq_out;
  logic          dram_dq_oe;
  logic [DW-1:0] dram_dq_in;

  always #10 clk = ~clk;

  pgdram_ctrl #(.MOD_CNT(MODS), .ROW_W(RW), .COL_W(CW), .DATA_W(DW),
                .T_PRE(TP), .T_RCD(TR), .T_CAS(TC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_a(dram_a), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in));

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29 + 7) ^ (a >> 2));
  endfunction

  // DRAM model
  logic [7:0] mem [0:NADDR-1];
  logic [1:0] row_lat [0:MODS-1];
  logic [5:0] cur_idx = '0;
  assign dram_dq_in = (!dram_oe_n && !dram_cas_n) ? mem[cur_idx] : 8'h00;

  // expectations for the running access
  int  exp_mod = 0, exp_row = 0, exp_col = 0;
  bit  exp_wr = 0, exp_miss = 0;
  logic [7:0] exp_wdata = '0;

  logic [MODS-1:0] prev_ras = '1;
  logic prev_cas = 1'b1, prev_dqoe = 1'b0, prev_rsp = 1'b0;
  int  since_ras = 0, cas_run = 0, high_run = 0;
  bit  had_open = 0;
  int  ras_falls = 0, rsp_cnt = 0, viol_weoe = 0, viol_multi = 0;
  logic [7:0] last_rdata = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!dram_we_n && !dram_oe_n) viol_weoe++;
      if ($countones(~dram_ras_n) > 1) viol_multi++;
      since_ras++;
      for (int i = 0; i < MODS; i++) begin
        if (prev_ras[i] && !dram_ras_n[i]) begin
          ras_falls++;
          since_ras = 0;
          row_lat[i] = dram_a;
          chk(i == exp_mod, "R3 ras line", i, exp_mod);
          chk(int'(dram_a) == exp_row, "R2 row on bus", int'(dram_a), exp_row);
          if (had_open) chk(high_run == TP + 1, "R5 precharge", high_run, TP + 1);
          had_open = 1;
        end
      end
      if (dram_ras_n == '1) high_run++; else high_run = 0;
      if (prev_cas && !dram_cas_n) begin
        int m;
        m = 0;
        for (int i = 0; i < MODS; i++) if (!dram_ras_n[i]) m = i;
        cur_idx = {2'(m), row_lat[m], dram_a};
        chk(int'(dram_a) == exp_col, "R2 col on bus", int'(dram_a), exp_col);
        if (exp_miss) chk(since_ras == TR + 1, "R6 ras to cas", since_ras, TR + 1);
        if (exp_wr) begin
          mem[cur_idx] = dram_dq_out;
          chk(!dram_we_n && dram_oe_n && dram_dq_oe && prev_dqoe, "R7 write strobes",
              {dram_we_n, dram_oe_n, dram_dq_oe, prev_dqoe}, 4'b0111);
          chk(dram_dq_out == exp_wdata, "R7 write data", dram_dq_out, exp_wdata);
        end else begin
          chk(!dram_oe_n && dram_we_n && !dram_dq_oe, "R8 read strobes",
              {dram_oe_n, dram_we_n, dram_dq_oe}, 3'b010);
        end
      end
      if (!dram_cas_n) cas_run++;
      if (!prev_cas && dram_cas_n) begin
        chk(cas_run == TC, "R6 cas width", cas_run, TC);
        cas_run = 0;
        if (exp_wr) chk(dram_dq_oe && !dram_we_n, "R7 drive after cas", dram_dq_oe, 1);
        else chk(dram_oe_n, "R8 oe off after cas", dram_oe_n, 1);
      end
      if (rsp_valid) begin
        chk(!prev_cas && dram_cas_n && !prev_rsp, "R8 rsp timing",
            {prev_cas, dram_cas_n, prev_rsp}, 3'b010);
        last_rdata = rsp_rdata;
        rsp_cnt++;
      end
      prev_ras  = dram_ras_n;
      prev_cas  = dram_cas_n;
      prev_dqoe = dram_dq_oe;
      prev_rsp  = rsp_valid;
    end
  end

  bit tb_open = 0;
  int tb_mod = 0, tb_row = 0;

  task automatic do_req(input bit wr, input int a);
    int m, r, c, busy, f0, r0, exp_busy;
    bit hit;
    m = a >> 4; r = (a >> 2) & 3; c = a & 3;
    hit = tb_open && (tb_mod == m) && (tb_row == r);
    exp_busy = hit ? TC + 2 : ((tb_open ? TP : 0) + TR + TC + 3);
    exp_mod = m; exp_row = r; exp_col = c;
    exp_wr = wr; exp_miss = !hit; exp_wdata = pat(a);
    f0 = ras_falls; r0 = rsp_cnt;
    req_valid = 1'b1; req_write = wr; req_addr = 6'(a); req_wdata = pat(a);
    @(posedge clk); #2;
    req_valid = 1'b0;
    chk(!req_ready, "R10 ready drops", req_ready, 0);
    busy = 1;
    while (!req_ready && busy < 1000) begin
      @(posedge clk); #2;
      if (!req_ready) busy++;
    end
    if (hit) chk(busy == exp_busy, "R4 hit length", busy, exp_busy);
    else     chk(busy == exp_busy, "R5 miss length", busy, exp_busy);
    chk(ras_falls - f0 == (hit ? 0 : 1), hit ? "R4 no ras edge" : "R3 one ras open",
        ras_falls - f0, hit ? 0 : 1);
    if (!wr) begin
      chk(rsp_cnt - r0 == 1, "R8 one response", rsp_cnt - r0, 1);
      chk(last_rdata == pat(a), "R8 read data", last_rdata, pat(a));
    end
    tb_open = 1; tb_mod = m; tb_row = r;
  endtask

  initial begin
    for (int i = 0; i < NADDR; i++) mem[i] = 8'h00;
    for (int i = 0; i < MODS; i++) row_lat[i] = 2'b00;
    repeat (3) @(posedge clk);
    #2;
    chk(dram_ras_n == '1 && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes idle",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 8'hFF);
    rst_n = 1'b1;
    @(posedge clk); #2;
    chk(req_ready && !rsp_valid && !dram_dq_oe, "R1 handshake idle",
        {req_ready, rsp_valid, dram_dq_oe}, 3'b100);
    chk(dram_ras_n == '1, "R1 no row open", dram_ras_n, 4'hF);
    for (int a = 0; a < NADDR; a++) do_req(1'b1, a);
    for (int i = 0; i < NADDR; i++) do_req(1'b0, (i * 5 + 3) % NADDR);
    do_req(1'b0, 17);
    do_req(1'b0, 17);
    do_req(1'b0, 49);
    do_req(1'b1, 50);
    do_req(1'b0, 50);
    repeat (4) @(posedge clk);
    #2;
    chk(viol_weoe == 0, "R9 we/oe overlap", viol_weoe, 0);
    chk(viol_multi == 0, "R3 multiple ras", viol_multi, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule